// File: doc/BRIEF.md
# SDRAM Bank State Tracker

This block watches the command stream sent to a four-bank SDRAM and keeps a model of every bank. For each bank it knows whether the bank is idle, has a row open, has an auto-precharge pending at the end of a burst, or is still recovering from a precharge. For open banks it also knows which row is open. Each command is checked against that model. A command that breaks a rule raises a one-cycle violation flag with a code, and it leaves the model untouched.

The burst length comes from the address bits of an accepted mode-register load. It sets how long a read or write with auto precharge keeps its row open. The precharge recovery time and the mode-register delay are parameters counted in clock cycles.

Each bank runs a four-state machine:
- IDLE goes to OPEN on an accepted activate.
- OPEN goes to AUTOPRE on an access with auto precharge, and to RECOVER on a precharge.
- AUTOPRE returns to OPEN on an access without auto precharge. It restarts on another access with auto precharge. It goes to RECOVER when the burst count runs out or on a precharge.
- RECOVER goes to IDLE when the recovery count expires.

The mode controller has two states. READY goes to SETTLE on an accepted mode load, and SETTLE returns to READY when the mode-register delay has passed. If a delay is one cycle, the matching intermediate state is skipped.

Top module: `sdram_bank_tracker`

## Requirements
- R1: `cmd_i` encoding: 0 inhibit, 1 no-op, 2 activate, 3 read, 4 write, 5 precharge, 6 burst stop, 7 mode load. An activate to an idle bank sets that bank's bit in `bank_open_o` on the next cycle. The row given on `addr_i` then appears at `bank_row_o[b*ROW_W +: ROW_W]`. The row field of a bank that is not open reads zero.
- R2: An activate to a bank that already has a row open gives violation code 2, and the open row is kept.
- R3: A read or write to an idle bank gives violation code 1, and no bank changes.
- R4: A read or write with `addr_i[10]`=1 keeps the row open for BL cycles after the command. The bank then recovers for TRP cycles and accepts a command BL+TRP cycles after the access. With `addr_i[10]`=0 the row stays open.
- R5: With full-page burst (mode code 7), `addr_i[10]` on a read or write is ignored, and the row stays open until an explicit precharge.
- R6: A precharge with `addr_i[10]`=1 closes every open bank, and `ba_i` is ignored. With `addr_i[10]`=0 it closes only bank `ba_i`. A precharge to an idle bank is legal and has no effect. A closed bank shows its bit in `bank_rcv_o` while it recovers.
- R7: A mode load while any bank is open or recovering gives code 3. Otherwise `addr_i[2:0]` sets the burst length: 0→1, 1→2, 2→4, 3→8, 7→full page, 4..6→1. Any command other than inhibit, no-op or burst stop that comes fewer than TMRD cycles after an accepted mode load gives code 4.
- R8: An activate, read, write or single-bank precharge to a bank that is recovering gives code 4. A command TRP cycles after the precharge is accepted.
- R9: Inhibit, no-op and burst stop change no bank state and raise no violation.
- R10: `viol_o` and `viol_code_o` are registered. They are valid in the cycle after the offending command and last that one cycle. The code is 0 when there is no violation, and a flagged command has no effect.
- R11: After reset, all banks are idle and not recovering, no violation is shown, and the burst length is 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 3 | Decoded command (encoding in R1) |
| ba_i | input | 2 | Bank address |
| addr_i | input | 12 | Address bus (row, A10 control, mode bits) |
| bank_open_o | output | 4 | Per-bank row-open flag |
| bank_rcv_o | output | 4 | Per-bank precharge-recovery flag |
| bank_row_o | output | 48 | Open row per bank, bank b at bits b*12 upward |
| viol_o | output | 1 | Rule violation, one cycle |
| viol_code_o | output | 3 | Violation code, 0 when none |

## Verification
An auto-precharge burst can end in the same cycle as a new command arrives at another bank or at the same bank. The bench issues a read with auto precharge, then counts no-ops so that an activate to that bank lands in the first and last recovery cycles. It expects code 4 in the first of those cycles and acceptance one cycle later. A second overlap is a mode load attempted while a bank is still recovering, followed by a command inside the mode-register delay. Code 3 is expected first, then code 4, and then acceptance once the delay has passed.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

    typedef enum logic [2:0] {
        CMD_INHIBIT = 3'd0,
        CMD_NOP     = 3'd1,
        CMD_ACT     = 3'd2,
        CMD_RD      = 3'd3,
        CMD_WR      = 3'd4,
        CMD_PRE     = 3'd5,
        CMD_BSTOP   = 3'd6,
        CMD_MRS     = 3'd7
    } sdram_cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE,
        BK_OPEN,
        BK_AUTOPRE,
        BK_RECOVER
    } bank_st_e;

    typedef enum logic [2:0] {
        VC_NONE        = 3'd0,
        VC_IDLE_ACCESS = 3'd1,
        VC_OPEN_ACT    = 3'd2,
        VC_MODE_BUSY   = 3'd3,
        VC_RECOVERY    = 3'd4
    } viol_code_e;

    localparam logic [2:0] BURST_CODE_FULL  = 3'd7;
    localparam logic [2:0] BURST_CODE_RESET = 3'd2;

endpackage

// File: rtl/sdram_mode_ctl.sv
module sdram_mode_ctl
    import sdram_trk_pkg::*;
#(
    parameter int TMRD  = 2,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [2:0]       code_i,
    output logic             busy_o,
    output logic             full_page_o,
    output logic [CNT_W-1:0] burst_m1_o
);

    localparam int MRD_W = (TMRD > 1) ? $clog2(TMRD + 1) : 1;

    typedef enum logic {MODE_READY, MODE_SETTLE} mode_st_e;

    mode_st_e         st_q, st_d;
    logic [MRD_W-1:0] cnt_q, cnt_d;
    logic [2:0]       code_q, code_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= MODE_READY;
            cnt_q  <= '0;
            code_q <= BURST_CODE_RESET;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            code_q <= code_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        code_d = code_q;
        unique case (st_q)
            MODE_READY: begin
                if (load_i) begin
                    code_d = code_i;
                    if (TMRD > 1) begin
                        st_d  = MODE_SETTLE;
                        cnt_d = MRD_W'(TMRD - 1);
                    end
                end
            end
            MODE_SETTLE: begin
                if (cnt_q <= MRD_W'(1)) begin
                    st_d  = MODE_READY;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q - MRD_W'(1);
                end
            end
        endcase
    end

    always_comb begin
        busy_o      = (st_q == MODE_SETTLE);
        full_page_o = (code_q == BURST_CODE_FULL);
        unique case (code_q)
            3'd1:    burst_m1_o = CNT_W'(1);
            3'd2:    burst_m1_o = CNT_W'(3);
            3'd3:    burst_m1_o = CNT_W'(7);
            default: burst_m1_o = '0;
        endcase
    end

    AST_LOAD_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !busy_o);  // R7
    AST_SETTLE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cnt_q == MRD_W'(1)) |=> !busy_o);  // R7

endmodule

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
    import sdram_trk_pkg::*;
#(
    parameter int ROW_W = 12,
    parameter int CNT_W = 3,
    parameter int TRP   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic             acc_i,
    input  logic             ap_i,
    input  logic             pre_i,
    input  logic [CNT_W-1:0] burst_m1_i,
    output bank_st_e         state_o,
    output logic [ROW_W-1:0] row_o
);

    localparam bank_st_e   AFTER_PRE = (TRP > 1) ? BK_RECOVER : BK_IDLE;
    localparam logic [CNT_W-1:0] RCV_LOAD = (TRP > 1) ? CNT_W'(TRP - 1) : '0;

    bank_st_e         st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [ROW_W-1:0] row_q, row_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= BK_IDLE;
            cnt_q <= '0;
            row_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            row_q <= row_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        row_d = row_q;
        unique case (st_q)
            BK_IDLE: begin
                if (act_i) begin
                    st_d  = BK_OPEN;
                    row_d = row_i;
                end
            end
            BK_OPEN: begin
                if (pre_i) begin
                    st_d  = AFTER_PRE;
                    cnt_d = RCV_LOAD;
                end else if (acc_i && ap_i) begin
                    st_d  = BK_AUTOPRE;
                    cnt_d = burst_m1_i;
                end
            end
            BK_AUTOPRE: begin
                if (pre_i) begin
                    st_d  = AFTER_PRE;
                    cnt_d = RCV_LOAD;
                end else if (acc_i) begin
                    st_d  = ap_i ? BK_AUTOPRE : BK_OPEN;
                    cnt_d = burst_m1_i;
                end else if (cnt_q == '0) begin
                    st_d  = AFTER_PRE;
                    cnt_d = RCV_LOAD;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            BK_RECOVER: begin
                if (cnt_q <= CNT_W'(1)) begin
                    st_d  = BK_IDLE;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
        endcase
    end

    always_comb begin
        state_o = st_q;
        row_o   = (st_q == BK_OPEN || st_q == BK_AUTOPRE) ? row_q : '0;
    end

    AST_ACT_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        act_i |-> st_q == BK_IDLE);  // R2
    AST_ACC_ONLY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        acc_i |-> (st_q == BK_OPEN || st_q == BK_AUTOPRE));  // R3
    AST_PRE_ONLY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        pre_i |-> (st_q == BK_OPEN || st_q == BK_AUTOPRE));  // R6
    AST_ROW_HELD_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BK_OPEN && !pre_i && !acc_i) |=> (st_q == BK_OPEN && $stable(row_o)));  // R1

endmodule

// File: rtl/sdram_cmd_arbiter.sv
module sdram_cmd_arbiter
    import sdram_trk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BA_W      = 2,
    parameter int ADDR_W    = 12,
    parameter int AP_BIT    = 10
) (
    input  logic [2:0]               cmd_i,
    input  logic [BA_W-1:0]          ba_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  bank_st_e [NUM_BANKS-1:0] bank_st_i,
    input  logic                     mode_busy_i,
    input  logic                     full_page_i,
    output logic [NUM_BANKS-1:0]     act_o,
    output logic [NUM_BANKS-1:0]     acc_o,
    output logic                     ap_o,
    output logic [NUM_BANKS-1:0]     pre_o,
    output logic                     mode_ld_o,
    output logic [2:0]               code_o
);

    sdram_cmd_e           cmd;
    logic [NUM_BANKS-1:0] sel, open_mask, busy_mask;
    bank_st_e             tgt_st;
    viol_code_e           code;

    always_comb begin
        cmd    = sdram_cmd_e'(cmd_i);
        sel    = NUM_BANKS'(1) << ba_i;
        tgt_st = bank_st_i[ba_i];
        for (int b = 0; b < NUM_BANKS; b++) begin
            open_mask[b] = (bank_st_i[b] == BK_OPEN) || (bank_st_i[b] == BK_AUTOPRE);
            busy_mask[b] = (bank_st_i[b] != BK_IDLE);
        end
    end

    always_comb begin
        act_o     = '0;
        acc_o     = '0;
        ap_o      = 1'b0;
        pre_o     = '0;
        mode_ld_o = 1'b0;
        code      = VC_NONE;
        unique case (cmd)
            CMD_ACT, CMD_RD, CMD_WR: begin
                if (mode_busy_i || tgt_st == BK_RECOVER) begin
                    code = VC_RECOVERY;
                end else if (cmd == CMD_ACT) begin
                    if (tgt_st == BK_IDLE) act_o = sel;
                    else                   code  = VC_OPEN_ACT;
                end else if (tgt_st == BK_IDLE) begin
                    code = VC_IDLE_ACCESS;
                end else begin
                    acc_o = sel;
                    ap_o  = addr_i[AP_BIT] && !full_page_i;
                end
            end
            CMD_PRE: begin
                if (mode_busy_i)                  code  = VC_RECOVERY;
                else if (addr_i[AP_BIT])          pre_o = open_mask;
                else if (tgt_st == BK_RECOVER)    code  = VC_RECOVERY;
                else                              pre_o = sel & open_mask;
            end
            CMD_MRS: begin
                if (mode_busy_i)        code      = VC_RECOVERY;
                else if (|busy_mask)    code      = VC_MODE_BUSY;
                else                    mode_ld_o = 1'b1;
            end
            CMD_INHIBIT, CMD_NOP, CMD_BSTOP: ;
        endcase
        code_o = code;
    end

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
    import sdram_trk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 12,
    parameter int TRP       = 2,
    parameter int TMRD      = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [2:0]                 cmd_i,
    input  logic [$clog2(NUM_BANKS)-1:0] ba_i,
    input  logic [ROW_W-1:0]           addr_i,
    output logic [NUM_BANKS-1:0]       bank_open_o,
    output logic [NUM_BANKS-1:0]       bank_rcv_o,
    output logic [NUM_BANKS*ROW_W-1:0] bank_row_o,
    output logic                       viol_o,
    output logic [2:0]                 viol_code_o
);

    localparam int BA_W  = $clog2(NUM_BANKS);
    localparam int CMAX  = (TRP > 8) ? TRP : 8;
    localparam int CNT_W = $clog2(CMAX);

    bank_st_e [NUM_BANKS-1:0]            bank_st;
    logic [NUM_BANKS-1:0][ROW_W-1:0]     rows;
    logic [NUM_BANKS-1:0]                act_v, acc_v, pre_v, ap_mask;
    logic                                ap, mode_ld, mode_busy, full_page;
    logic [CNT_W-1:0]                    burst_m1;
    logic [2:0]                          code_d, code_q;

    sdram_mode_ctl #(.TMRD(TMRD), .CNT_W(CNT_W)) u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (mode_ld),
        .code_i      (addr_i[2:0]),
        .busy_o      (mode_busy),
        .full_page_o (full_page),
        .burst_m1_o  (burst_m1)
    );

    sdram_cmd_arbiter #(
        .NUM_BANKS (NUM_BANKS),
        .BA_W      (BA_W),
        .ADDR_W    (ROW_W),
        .AP_BIT    (10)
    ) u_arb (
        .cmd_i       (cmd_i),
        .ba_i        (ba_i),
        .addr_i      (addr_i),
        .bank_st_i   (bank_st),
        .mode_busy_i (mode_busy),
        .full_page_i (full_page),
        .act_o       (act_v),
        .acc_o       (acc_v),
        .ap_o        (ap),
        .pre_o       (pre_v),
        .mode_ld_o   (mode_ld),
        .code_o      (code_d)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        sdram_bank_fsm #(.ROW_W(ROW_W), .CNT_W(CNT_W), .TRP(TRP)) u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .act_i      (act_v[g]),
            .row_i      (addr_i),
            .acc_i      (acc_v[g]),
            .ap_i       (ap),
            .pre_i      (pre_v[g]),
            .burst_m1_i (burst_m1),
            .state_o    (bank_st[g]),
            .row_o      (rows[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) code_q <= '0;
        else        code_q <= code_d;
    end

    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            bank_open_o[b] = (bank_st[b] == BK_OPEN) || (bank_st[b] == BK_AUTOPRE);
            bank_rcv_o[b]  = (bank_st[b] == BK_RECOVER);
            ap_mask[b]     = (bank_st[b] == BK_AUTOPRE);
        end
        bank_row_o  = rows;
        viol_code_o = code_q;
        viol_o      = (code_q != 3'd0);
    end

    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |-> (viol_code_o >= 3'd1 && viol_code_o <= 3'd4));  // R10
    AST_NO_AP_FULLPAGE: assert property (@(posedge clk) disable iff (!rst_n)
        full_page |-> ap_mask == '0);  // R5
    AST_DOUBLE_ACT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_ACT && bank_open_o[ba_i]) |=> viol_o);  // R2
    AST_OPEN_RCV_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_open_o & bank_rcv_o) == '0);  // R6
    AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_NOP || cmd_i == CMD_INHIBIT || cmd_i == CMD_BSTOP) |=> !viol_o);  // R9

endmodule

// File: tb/test_sdram_bank_tracker.sv
`timescale 1ns/1ps
module test_sdram_bank_tracker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd_i = 3'd1;
    logic [1:0]  ba_i = '0;
    logic [11:0] addr_i = '0;
    logic [3:0]  bank_open_o, bank_rcv_o;
    logic [47:0] bank_row_o;
    logic        viol_o;
    logic [2:0]  viol_code_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sdram_bank_tracker i_sdram_bank_tracker (
        .clk (clk), .rst_n (rst_n), .cmd_i (cmd_i), .ba_i (ba_i), .addr_i (addr_i),
        .bank_open_o (bank_open_o), .bank_rcv_o (bank_rcv_o), .bank_row_o (bank_row_o),
        .viol_o (viol_o), .viol_code_o (viol_code_o)
    );

    typedef struct packed {
        logic [2:0]  cmd;
        logic [1:0]  ba;
        logic [11:0] addr;
        logic [2:0]  code;
        logic [3:0]  opn;
        logic [3:0]  rcv;
    } vec_t;

    localparam int NV = 37;
    localparam vec_t VEC [0:NV-1] = '{
        '{3'd1, 2'd0, 12'h000, 3'd0, 4'b0000, 4'b0000}, // 0  R9 nop
        '{3'd2, 2'd0, 12'h123, 3'd0, 4'b0001, 4'b0000}, // 1  R1 act b0
        '{3'd2, 2'd2, 12'h456, 3'd0, 4'b0101, 4'b0000}, // 2  R1 act b2
        '{3'd2, 2'd0, 12'h007, 3'd2, 4'b0101, 4'b0000}, // 3  R2 act open
        '{3'd3, 2'd1, 12'h000, 3'd1, 4'b0101, 4'b0000}, // 4  R3 read idle
        '{3'd4, 2'd2, 12'h000, 3'd0, 4'b0101, 4'b0000}, // 5  R4 write no ap
        '{3'd5, 2'd0, 12'h000, 3'd0, 4'b0100, 4'b0001}, // 6  R6 pre b0
        '{3'd2, 2'd0, 12'h000, 3'd4, 4'b0100, 4'b0000}, // 7  R8 act in recovery
        '{3'd2, 2'd0, 12'h0AA, 3'd0, 4'b0101, 4'b0000}, // 8  R8 act after TRP
        '{3'd3, 2'd0, 12'h400, 3'd0, 4'b0101, 4'b0000}, // 9  R4 read ap BL4
        '{3'd1, 2'd0, 12'h000, 3'd0, 4'b0101, 4'b0000}, // 10 R4
        '{3'd1, 2'd0, 12'h000, 3'd0, 4'b0101, 4'b0000}, // 11 R4
        '{3'd1, 2'd0, 12'h000, 3'd0, 4'b0101, 4'b0000}, // 12 R4
        '{3'd1, 2'd0, 12'h000, 3'd0, 4'b0100, 4'b0001}, // 13 R4 burst end
        '{3'd2, 2'd0, 12'h000, 3'd4, 4'b0100, 4'b0000}, // 14 R8
        '{3'd2, 2'd0, 12'h3FF, 3'd0, 4'b0101, 4'b0000}, // 15 R8 legal at BL+TRP
        '{3'd7, 2'd0, 12'h007, 3'd3, 4'b0101, 4'b0000}, // 16 R7 load while open
        '{3'd5, 2'd1, 12'h400, 3'd0, 4'b0000, 4'b0101}, // 17 R6 pre all
        '{3'd7, 2'd0, 12'h007, 3'd3, 4'b0000, 4'b0000}, // 18 R7 load while recovering
        '{3'd7, 2'd0, 12'h007, 3'd0, 4'b0000, 4'b0000}, // 19 R7 load full page
        '{3'd2, 2'd1, 12'h011, 3'd4, 4'b0000, 4'b0000}, // 20 R7 inside TMRD
        '{3'd2, 2'd1, 12'h011, 3'd0, 4'b0010, 4'b0000}, // 21 R1
        '{3'd4, 2'd1, 12'h400, 3'd0, 4'b0010, 4'b0000}, // 22 R5 ap ignored
        '{3'd1, 2'd0, 12'h000, 3'd0, 4'b0010, 4'b0000}, // 23 R5
        '{3'd1, 2'd0, 12'h000, 3'd0, 4'b0010, 4'b0000}, // 24 R5
        '{3'd1, 2'd0, 12'h000, 3'd0, 4'b0010, 4'b0000}, // 25 R5
        '{3'd1, 2'd0, 12'h000, 3'd0, 4'b0010, 4'b0000}, // 26 R5
        '{3'd0, 2'd1, 12'h400, 3'd0, 4'b0010, 4'b0000}, // 27 R9 inhibit
        '{3'd6, 2'd1, 12'h400, 3'd0, 4'b0010, 4'b0000}, // 28 R9 burst stop
        '{3'd5, 2'd1, 12'h000, 3'd0, 4'b0000, 4'b0010}, // 29 R6 pre b1
        '{3'd1, 2'd0, 12'h000, 3'd0, 4'b0000, 4'b0000}, // 30 R6
        '{3'd7, 2'd0, 12'h000, 3'd0, 4'b0000, 4'b0000}, // 31 R7 load BL1
        '{3'd1, 2'd0, 12'h000, 3'd0, 4'b0000, 4'b0000}, // 32 R9
        '{3'd2, 2'd3, 12'h800, 3'd0, 4'b1000, 4'b0000}, // 33 R1
        '{3'd4, 2'd3, 12'h400, 3'd0, 4'b1000, 4'b0000}, // 34 R4 write ap BL1
        '{3'd1, 2'd0, 12'h000, 3'd0, 4'b0000, 4'b1000}, // 35 R4
        '{3'd1, 2'd0, 12'h000, 3'd0, 4'b0000, 4'b0000}  // 36 R4
    };

    function automatic string vec_req(int i);
        case (i)
            0, 27, 28, 32:           return "R9";
            1, 2, 21, 33:            return "R1";
            3:                       return "R2";
            4:                       return "R3";
            7, 8, 14, 15:            return "R8";
            6, 17, 29, 30:           return "R6";
            16, 18, 19, 20, 31:      return "R7";
            22, 23, 24, 25, 26:      return "R5";
            default:                 return "R4";
        endcase
    endfunction

    task automatic chk(string req, string what, logic [47:0] act, logic [47:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(logic [2:0] c, logic [1:0] b, logic [11:0] a);
        cmd_i = c; ba_i = b; addr_i = a;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R11", "open after reset", 48'(bank_open_o), 48'h0);
        chk("R11", "rcv after reset", 48'(bank_rcv_o), 48'h0);
        chk("R11", "viol after reset", 48'({viol_o, viol_code_o}), 48'h0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].cmd, VEC[i].ba, VEC[i].addr);
            chk(vec_req(i), $sformatf("vec %0d code", i), 48'(viol_code_o), 48'(VEC[i].code));
            chk(vec_req(i), $sformatf("vec %0d open", i), 48'(bank_open_o), 48'(VEC[i].opn));
            chk(vec_req(i), $sformatf("vec %0d rcv", i), 48'(bank_rcv_o), 48'(VEC[i].rcv));
        end

        // R1 row value and masking
        step(3'd2, 2'd2, 12'hABC);
        chk("R1", "row b2", 48'(bank_row_o[24 +: 12]), 48'hABC);
        chk("R1", "other rows zero", 48'({bank_row_o[0 +: 24], bank_row_o[36 +: 12]}), 48'h0);
        // R2 double activate keeps row
        step(3'd2, 2'd2, 12'h123);
        chk("R2", "flag on double act", 48'(viol_o), 48'h1);
        chk("R2", "row kept", 48'(bank_row_o[24 +: 12]), 48'hABC);
        // R10 flag lasts one cycle
        step(3'd1, 2'd0, 12'h000);
        chk("R10", "flag cleared", 48'({viol_o, viol_code_o}), 48'h0);
        // R6 single-bank precharge of idle bank is no-op, other bank stays
        step(3'd5, 2'd0, 12'h000);
        chk("R6", "pre idle bank no effect", 48'({bank_open_o, bank_rcv_o}), 48'h40);
        chk("R6", "pre idle no flag", 48'(viol_o), 48'h0);
        // R11 reset clears open state and burst length back to 4
        rst_n = 1'b0;
        step(3'd1, 2'd0, 12'h000);
        rst_n = 1'b1;
        chk("R11", "open after mid reset", 48'(bank_open_o), 48'h0);
        chk("R11", "row after mid reset", bank_row_o, 48'h0);
        step(3'd2, 2'd1, 12'h055);
        step(3'd3, 2'd1, 12'h400);
        step(3'd1, 2'd0, 12'h000);
        step(3'd1, 2'd0, 12'h000);
        step(3'd1, 2'd0, 12'h000);
        chk("R11", "BL4 still open", 48'(bank_open_o), 48'h2);
        step(3'd1, 2'd0, 12'h000);
        chk("R11", "BL4 closed", 48'({bank_open_o, bank_rcv_o}), 48'h02);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule